// File: doc/BRIEF.md
# Shared Count and Compare Timer

This block keeps one free-running counter that every processor in a cluster shares, plus one compare register per processor. When the shared count reaches or passes a processor's compare value, a sticky pending flag for that processor rises and drives its count/compare interrupt output. Software reprograms the compare value to acknowledge the interrupt and to schedule the next one.

All state is reached through a simple register bus with separate read and write strobes and a byte address. An access is either narrow (32 bits, data on the low half of the data buses) or wide (64 bits, 8-byte aligned addresses only). The counter can be read or written as one wide word or as two narrow halves. A narrow read of the low half captures the high half, so that a narrow read of the high half that follows returns a coherent 64-bit snapshot. A configuration word holds a stop control that freezes the counter and reports the counter width as a fixed code.

Counter width, processor count and address width are parameters checked at elaboration. Routing of the interrupt outputs to pins is left to the surrounding logic.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset the counter, the stop control, the captured high half and every pending flag are zero, and every compare register holds all ones.
- R2: With the stop control clear and no counter write, the counter increases by one on every clock.
- R3: While the stop control (bit 28 of the configuration word at byte offset 0x000) is set, the counter keeps its value; bit 28 reads back as written.
- R4: Bits 27:24 of the configuration word read (CNT_W-32)/4, which is 8 for the default 64-bit counter; all other configuration bits except bit 28 read zero, and writes to them are ignored.
- R5: A narrow write to offset 0x010 replaces the low 32 bits and one to offset 0x014 replaces the high bits of the counter; the other half keeps its value from the write cycle, the written value is visible on the next cycle and counting resumes from it.
- R6: A wide access at offset 0x010 reads or writes the full counter in one operation, low 32 bits on data bits 31:0; a wide read returns the live value and does not touch the captured high half.
- R7: A narrow read at 0x010 returns the live low 32 bits and captures the live high half; a narrow read at 0x014 returns the most recently captured high half.
- R8: Processor i's compare register sits at offset 0x100 + 8*i (low half, or the full value on a wide access) and 0x100 + 8*i + 4 (high half, narrow only), and reads back as written; unmapped offsets read zero.
- R9: Processor i's pending flag, driven on irq bit i, sets on the clock after a cycle in which the counter is greater than or equal to its compare value, and stays set even if the counter later drops below.
- R10: Any write to processor i's compare register clears its pending flag on that clock, taking priority over a match in the same cycle, and leaves other processors' flags alone.
- R11: The counter wraps from all ones to zero and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, data returned combinationally on bus_rdata |
| bus_wr | input | 1 | Write strobe, takes effect on the rising clock edge |
| bus_wide | input | 1 | 1 selects a 64-bit access, 0 a 32-bit access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 64 | Write data; narrow accesses use bits 31:0 |
| bus_rdata | output | 64 | Read data; zero when bus_rd is low |
| irq | output | NUM_CPU | Per-processor count/compare pending flags |

## Verification
The hardest condition to reach is a pending flag raised, then the counter moved back below the compare value, while another processor's flag stays set and a compare write to a third arrives in the same cycle as a fresh match. A free-running 64-bit counter from reset never approaches an all-ones compare, so the stimulus writes compare values a few counts ahead of a bench-tracked counter value and writes counter values just below the programmed compares, and a random phase keeps biasing both that way. Snapshot coherence is forced by reading the low half just before a carry into the high half and reading the high half after it.

// File: rtl/gct_pkg.sv
package gct_pkg;
   // Byte offsets the software view depends on
   localparam int unsigned OFS_CFG      = 'h000;
   localparam int unsigned OFS_CNT_LO   = 'h010;
   localparam int unsigned OFS_CNT_HI   = 'h014;
   localparam int unsigned CMP_WIN_PAGE = 1;     // compare window at 0x100..0x1FF
   // Configuration word fields
   localparam int unsigned STOP_BIT  = 28;
   localparam int unsigned WCODE_LSB = 24;
   localparam int unsigned WCODE_W   = 4;
   localparam int unsigned HALF_W    = 32;

   function automatic logic [WCODE_W-1:0] width_code(input int unsigned w);
      return WCODE_W'((w - 32) / 4);
   endfunction
endpackage

// File: rtl/gct_regbus.sv
module gct_regbus
   import gct_pkg::*;
#(
   parameter int unsigned NUM_CPU = 2,
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned ADDR_W  = 12
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bus_rd,
   input  logic                            bus_wr,
   input  logic                            bus_wide,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [63:0]                     bus_wdata,
   output logic [63:0]                     bus_rdata,
   // decoded strobes
   output logic                            cfg_we,
   output logic                            cnt_we_lo,
   output logic                            cnt_we_hi,
   output logic                            cnt_rd_lo,
   output logic [NUM_CPU-1:0]              cmp_we_lo,
   output logic [NUM_CPU-1:0]              cmp_we_hi,
   output logic [HALF_W-1:0]               wr_lo_data,
   output logic [HALF_W-1:0]               wr_hi_data,
   // state for read back
   input  logic                            stop,
   input  logic [CNT_W-1:0]                cnt,
   input  logic [CNT_W-HALF_W-1:0]         hi_latch,
   input  logic [NUM_CPU-1:0][CNT_W-1:0]   cmp_vals
);
   localparam logic [WCODE_W-1:0] WCODE = width_code(CNT_W);
   localparam int unsigned        IDX_LO = 3;
   localparam int unsigned        PAGE_LSB = 8;

   logic               cfg_hit, cnt_lo_hit, cnt_hi_hit, in_cmp_win;
   logic [NUM_CPU-1:0] cmp_hit;

   assign cfg_hit    = (bus_addr == ADDR_W'(OFS_CFG));
   assign cnt_lo_hit = (bus_addr == ADDR_W'(OFS_CNT_LO));
   assign cnt_hi_hit = (bus_addr == ADDR_W'(OFS_CNT_HI)) && !bus_wide;
   assign in_cmp_win = (bus_addr[ADDR_W-1:PAGE_LSB] == (ADDR_W-PAGE_LSB)'(CMP_WIN_PAGE))
                       && (bus_addr[1:0] == 2'b00);

   assign cfg_we     = bus_wr && cfg_hit;
   assign cnt_we_lo  = bus_wr && cnt_lo_hit;
   assign cnt_we_hi  = bus_wr && (cnt_hi_hit || (cnt_lo_hit && bus_wide));
   assign cnt_rd_lo  = bus_rd && cnt_lo_hit && !bus_wide;
   assign wr_lo_data = bus_wdata[HALF_W-1:0];
   assign wr_hi_data = bus_wide ? bus_wdata[63:HALF_W] : bus_wdata[HALF_W-1:0];

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_cmp_dec
      assign cmp_hit[i]   = in_cmp_win && (bus_addr[PAGE_LSB-1:IDX_LO] == (PAGE_LSB-IDX_LO)'(i));
      assign cmp_we_lo[i] = bus_wr && cmp_hit[i] && !bus_addr[2];
      assign cmp_we_hi[i] = bus_wr && cmp_hit[i] && (bus_wide ? !bus_addr[2] : bus_addr[2]);
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (cfg_hit) begin
            bus_rdata[STOP_BIT]               = stop;
            bus_rdata[WCODE_LSB +: WCODE_W]   = WCODE;
         end else if (cnt_lo_hit) begin
            bus_rdata[HALF_W-1:0] = cnt[HALF_W-1:0];
            if (bus_wide) bus_rdata[63:HALF_W] = HALF_W'(cnt[CNT_W-1:HALF_W]);
         end else if (cnt_hi_hit) begin
            bus_rdata[HALF_W-1:0] = HALF_W'(hi_latch);
         end else begin
            for (int i = 0; i < NUM_CPU; i++) begin
               if (cmp_hit[i]) begin
                  if (!bus_addr[2]) begin
                     bus_rdata[HALF_W-1:0] = cmp_vals[i][HALF_W-1:0];
                     if (bus_wide) bus_rdata[63:HALF_W] = HALF_W'(cmp_vals[i][CNT_W-1:HALF_W]);
                  end else if (!bus_wide) begin
                     bus_rdata[HALF_W-1:0] = HALF_W'(cmp_vals[i][CNT_W-1:HALF_W]);
                  end
               end
            end
         end
      end
   end

   // R8: a single access never targets two processors' compare registers
   a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmp_we_lo | cmp_we_hi));
   // R6: a wide counter write always updates both halves together
   a_r6_wide_both: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_we_lo && bus_wide) |-> cnt_we_hi);
endmodule

// File: rtl/gct_counter.sv
module gct_counter
   import gct_pkg::*;
#(
   parameter int unsigned CNT_W = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic                     cfg_stop,
   input  logic                     we_lo,
   input  logic                     we_hi,
   input  logic [HALF_W-1:0]        lo_data,
   input  logic [HALF_W-1:0]        hi_data,
   input  logic                     rd_lo,
   output logic [CNT_W-1:0]         cnt,
   output logic [CNT_W-HALF_W-1:0]  hi_latch,
   output logic                     stop
);
   localparam int unsigned HI_W = CNT_W - HALF_W;

   logic [CNT_W-1:0] cnt_q;
   logic [HI_W-1:0]  hi_latch_q;
   logic             stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (we_lo || we_hi) begin
         if (we_lo) cnt_q[HALF_W-1:0]     <= lo_data;
         if (we_hi) cnt_q[CNT_W-1:HALF_W] <= hi_data[HI_W-1:0];
      end else if (!stop_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stop_q <= 1'b0;
      else if (cfg_we) stop_q <= cfg_stop;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_latch_q <= '0;
      else if (rd_lo) hi_latch_q <= cnt_q[CNT_W-1:HALF_W];
   end

   assign cnt      = cnt_q;
   assign hi_latch = hi_latch_q;
   assign stop     = stop_q;

   a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_q && !we_lo && !we_hi) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !we_lo && !we_hi) |=> cnt_q == $past(cnt_q));
   a_r5_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
      (we_lo && !we_hi) |=> cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W]));
   a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> hi_latch_q == $past(cnt_q[CNT_W-1:HALF_W]));
endmodule

// File: rtl/gct_compare.sv
module gct_compare
   import gct_pkg::*;
#(
   parameter int unsigned CNT_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [HALF_W-1:0] lo_data,
   input  logic [HALF_W-1:0] hi_data,
   input  logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  cmp_val,
   output logic              pend
);
   localparam int unsigned HI_W = CNT_W - HALF_W;

   logic [CNT_W-1:0] cmp_q;
   logic             pend_q;
   logic             reached;

   assign reached = (cnt >= cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '1;
      end else begin
         if (we_lo) cmp_q[HALF_W-1:0]     <= lo_data;
         if (we_hi) cmp_q[CNT_W-1:HALF_W] <= hi_data[HI_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pend_q <= 1'b0;
      else if (we_lo || we_hi) pend_q <= 1'b0;
      else if (reached)        pend_q <= 1'b1;
   end

   assign cmp_val = cmp_q;
   assign pend    = pend_q;

   a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (we_lo || we_hi) |=> !pend_q);
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !we_lo && !we_hi) |=> pend_q);
   a_r9_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt >= cmp_q) && !we_lo && !we_hi) |=> pend_q);
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp
   import gct_pkg::*;
#(
   parameter int unsigned NUM_CPU = 2,
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned ADDR_W  = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic               bus_wide,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [63:0]        bus_wdata,
   output logic [63:0]        bus_rdata,
   output logic [NUM_CPU-1:0] irq
);
   localparam int unsigned HI_W = CNT_W - HALF_W;

   if (CNT_W < 36 || CNT_W > 64 || (CNT_W % 4) != 0) begin : g_bad_cnt_w
      $error("gtimer_cmp: CNT_W must be a multiple of 4 in 36..64");
   end
   if (NUM_CPU < 1 || NUM_CPU > 32) begin : g_bad_num_cpu
      $error("gtimer_cmp: NUM_CPU must be in 1..32");
   end
   if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_addr_w
      $error("gtimer_cmp: ADDR_W must be in 9..32");
   end

   logic                          cfg_we, cnt_we_lo, cnt_we_hi, cnt_rd_lo, stop;
   logic [NUM_CPU-1:0]            cmp_we_lo, cmp_we_hi;
   logic [HALF_W-1:0]             wr_lo_data, wr_hi_data;
   logic [CNT_W-1:0]              cnt;
   logic [HI_W-1:0]               hi_latch;
   logic [NUM_CPU-1:0][CNT_W-1:0] cmp_vals;

   gct_regbus #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regbus (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wide  (bus_wide),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cfg_we    (cfg_we),
      .cnt_we_lo (cnt_we_lo),
      .cnt_we_hi (cnt_we_hi),
      .cnt_rd_lo (cnt_rd_lo),
      .cmp_we_lo (cmp_we_lo),
      .cmp_we_hi (cmp_we_hi),
      .wr_lo_data(wr_lo_data),
      .wr_hi_data(wr_hi_data),
      .stop      (stop),
      .cnt       (cnt),
      .hi_latch  (hi_latch),
      .cmp_vals  (cmp_vals)
   );

   gct_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_stop (bus_wdata[STOP_BIT]),
      .we_lo    (cnt_we_lo),
      .we_hi    (cnt_we_hi),
      .lo_data  (wr_lo_data),
      .hi_data  (wr_hi_data),
      .rd_lo    (cnt_rd_lo),
      .cnt      (cnt),
      .hi_latch (hi_latch),
      .stop     (stop)
   );

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
      gct_compare #(.CNT_W(CNT_W)) u_compare (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_lo   (cmp_we_lo[i]),
         .we_hi   (cmp_we_hi[i]),
         .lo_data (wr_lo_data),
         .hi_data (wr_hi_data),
         .cnt     (cnt),
         .cmp_val (cmp_vals[i]),
         .pend    (irq[i])
      );
   end

   // R1: no interrupt is pending on the first cycle after reset release
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> irq == '0);
endmodule

// File: tb/gtimer_cmp_bench.sv
module gtimer_cmp_bench;
   localparam int NCPU = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic [NCPU-1:0] irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   gtimer_cmp #(.NUM_CPU(NCPU), .CNT_W(64), .ADDR_W(12)) u_gtimer_cmp (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wide(bus_wide),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // Expected state, built from the requirements
   logic [63:0] m_cnt, m_cmp [NCPU];
   logic [31:0] m_latch;
   logic        m_stop;
   logic [NCPU-1:0] m_pend;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_latch = '0; m_stop = 1'b0; m_pend = '0;
         for (int i = 0; i < NCPU; i++) m_cmp[i] = '1;
      end else begin
         logic lo_hit, wlo, whi;
         logic [31:0] hid;
         logic [63:0] n_cnt;
         lo_hit = (bus_addr == 12'h010);
         wlo = bus_wr && lo_hit;
         whi = bus_wr && ((bus_addr == 12'h014 && !bus_wide) || (lo_hit && bus_wide));
         hid = bus_wide ? bus_wdata[63:32] : bus_wdata[31:0];
         n_cnt = m_cnt;
         if (wlo || whi) begin
            if (wlo) n_cnt[31:0]  = bus_wdata[31:0];
            if (whi) n_cnt[63:32] = hid;
         end else if (!m_stop) n_cnt = m_cnt + 64'd1;
         if (bus_rd && lo_hit && !bus_wide) m_latch = m_cnt[63:32];
         for (int i = 0; i < NCPU; i++) begin
            logic hit, clo, chi;
            hit = (bus_addr[11:3] == 9'(32 + i)) && (bus_addr[1:0] == 2'b00);
            clo = bus_wr && hit && !bus_addr[2];
            chi = bus_wr && hit && (bus_wide ? !bus_addr[2] : bus_addr[2]);
            m_pend[i] = (clo || chi) ? 1'b0 : (m_pend[i] || (m_cnt >= m_cmp[i]));
            if (clo) m_cmp[i][31:0]  = bus_wdata[31:0];
            if (chi) m_cmp[i][63:32] = hid;
         end
         if (bus_wr && bus_addr == 12'h000) m_stop = bus_wdata[28];
         m_cnt = n_cnt;
      end
   end

   function automatic logic [63:0] exp_read(input logic [11:0] a, input logic w);
      if (a == 12'h000) return {32'h0, 3'b000, m_stop, 4'd8, 24'h0};
      if (a == 12'h010) return w ? m_cnt : {32'h0, m_cnt[31:0]};
      if (a == 12'h014) return w ? 64'h0 : {32'h0, m_latch};
      if (a[11:8] == 4'h1 && a[1:0] == 2'b00 && int'(a[7:3]) < NCPU) begin
         if (!a[2]) return w ? m_cmp[a[7:3]] : {32'h0, m_cmp[a[7:3]][31:0]};
         return w ? 64'h0 : {32'h0, m_cmp[a[7:3]][63:32]};
      end
      return 64'h0;
   endfunction

   function automatic string auto_tag(input logic [11:0] a, input logic w);
      if (a == 12'h000) return "R4";
      if (a == 12'h010) return w ? "R6" : "R7";
      if (a == 12'h014) return "R7";
      return "R8";
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // One bus cycle: drive at the falling edge, check outputs before the rising edge
   task automatic cyc(input logic rd, input logic wr, input logic wide,
                      input logic [11:0] a, input logic [63:0] d, input string tag);
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_wide = wide; bus_addr = a; bus_wdata = d;
      #1;
      chk((tag == "") ? "R9 irq" : {tag, " irq"}, 64'(irq), 64'(m_pend));
      if (rd) chk((tag == "") ? auto_tag(a, wide) : tag, bus_rdata, exp_read(a, wide));
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 12'h0, 64'h0, tag);
   endtask

   task automatic rand_op();
      logic [11:0] addrs [10];
      logic [11:0] a;
      logic [63:0] d;
      logic w, rd, wr;
      int unsigned op;
      addrs = '{12'h000, 12'h010, 12'h014, 12'h100, 12'h104, 12'h108,
                12'h10C, 12'h110, 12'h114, 12'h020};
      a  = addrs[$urandom_range(0, 9)];
      op = $urandom_range(0, 9);
      rd = (op < 4);
      wr = (op >= 4 && op < 7);
      w  = !a[2] && ($urandom_range(0, 1) == 1);
      d  = {$urandom, $urandom};
      if (a[8]) begin
         if ($urandom_range(0, 1) == 1) d = m_cnt + 64'($urandom_range(0, 40));
      end else if (a == 12'h010 || a == 12'h014) begin
         if ($urandom_range(0, 2) == 0) d = m_cmp[$urandom_range(0, NCPU-1)] - 64'($urandom_range(0, 20));
      end else if (a == 12'h000) begin
         d[28] = ($urandom_range(0, 3) == 0);
      end
      cyc(rd, wr, w, a, d, "");
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      cyc(1'b1, 1'b0, 1'b0, 12'h000, 64'h0, "R1");
      cyc(1'b1, 1'b0, 1'b1, 12'h100, 64'h0, "R1");
      cyc(1'b1, 1'b0, 1'b0, 12'h114, 64'h0, "R1");
      cyc(1'b1, 1'b0, 1'b0, 12'h014, 64'h0, "R1");

      // R2 free running
      cyc(1'b1, 1'b0, 1'b1, 12'h010, 64'h0, "R2");
      idle(5, "R2");
      cyc(1'b1, 1'b0, 1'b1, 12'h010, 64'h0, "R2");

      // R4 width code fixed, R3 stop holds
      cyc(1'b0, 1'b1, 1'b0, 12'h000, 64'hFFFF_FFFF, "R4");
      cyc(1'b1, 1'b0, 1'b0, 12'h000, 64'h0, "R4");
      cyc(1'b1, 1'b0, 1'b1, 12'h010, 64'h0, "R3");
      idle(4, "R3");
      cyc(1'b1, 1'b0, 1'b1, 12'h010, 64'h0, "R3");
      cyc(1'b0, 1'b1, 1'b0, 12'h000, 64'h0, "R3");
      cyc(1'b1, 1'b0, 1'b0, 12'h000, 64'h0, "R3");

      // R5 narrow half writes
      cyc(1'b0, 1'b1, 1'b0, 12'h010, 64'hDEAD_0000_0000_1234, "R5");
      cyc(1'b1, 1'b0, 1'b1, 12'h010, 64'h0, "R5");
      cyc(1'b0, 1'b1, 1'b0, 12'h014, 64'h0000_0000_0000_ABCD, "R5");
      cyc(1'b1, 1'b0, 1'b1, 12'h010, 64'h0, "R5");

      // R11 wrap through all ones
      cyc(1'b0, 1'b1, 1'b1, 12'h010, 64'hFFFF_FFFF_FFFF_FFFE, "R11");
      idle(2, "R11");
      cyc(1'b1, 1'b0, 1'b1, 12'h010, 64'h0, "R11");

      // R7 coherent snapshot across a carry into the high half
      cyc(1'b0, 1'b1, 1'b1, 12'h010, 64'h0000_0005_FFFF_FFFE, "R7");
      cyc(1'b1, 1'b0, 1'b0, 12'h010, 64'h0, "R7");
      idle(3, "R7");
      cyc(1'b1, 1'b0, 1'b0, 12'h014, 64'h0, "R7");
      cyc(1'b1, 1'b0, 1'b1, 12'h010, 64'h0, "R6");

      // R9 / R10 compare, sticky flag, per-processor clear
      cyc(1'b0, 1'b1, 1'b1, 12'h010, 64'd100, "R9");
      cyc(1'b0, 1'b1, 1'b1, 12'h108, 64'd110, "R8");
      cyc(1'b0, 1'b1, 1'b1, 12'h110, 64'd0, "R9");
      idle(14, "R9");
      cyc(1'b0, 1'b1, 1'b1, 12'h010, 64'd0, "R9");
      idle(3, "R9");
      cyc(1'b0, 1'b1, 1'b0, 12'h108, 64'd500, "R10");
      idle(2, "R10");
      cyc(1'b1, 1'b0, 1'b1, 12'h108, 64'h0, "R8");
      cyc(1'b1, 1'b0, 1'b0, 12'h10C, 64'h0, "R8");
      cyc(1'b1, 1'b0, 1'b0, 12'h020, 64'h0, "R8");

      // Constrained random phase
      for (int k = 0; k < 4000; k++) rand_op();
      idle(3, "");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule